// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block connects a synchronous request port to an external asynchronous static RAM of 65,536 sixteen-bit words. A requester presents a word address, write data, a two-bit lane mask and a read/write flag under a valid/ready handshake. The controller then runs one single-word access on the memory pins. It drives active-low chip-select, output-enable, write-strobe and per-lane enable lines, the address, and a shared tri-state data bus. Read data comes back with a one-clock valid strobe.

Every analog minimum is converted at elaboration into a whole number of clocks. The clock period and each nanosecond limit are parameters, and each count is the ceiling of the limit divided by the period. With a 5 ns clock, a read holds output-enable low for 11 cycles, followed by a 4-cycle bus turnaround. A write sets up for 1 cycle, holds the write strobe low for 9 cycles and holds for 1 cycle. Writes are strobe-controlled: output-enable stays high for the whole write cycle.

Top module: `sram_lane_ctrl`

## Requirements
- R1: During and after reset, until a request arrives, ready is 1, chip-select, output-enable and write-strobe are high, both lane enables are high and the read-valid strobe is 0.
- R2: For a read, output-enable is low for exactly RD_CYC = max(ceil(tRC), ceil(tAA), ceil(tOE)) cycles (11 at 5 ns). The data is registered at the end of that window. The read-valid strobe is high for exactly one clock, RD_CYC+1 clock edges after acceptance.
- R3: Mask bit 0 enables data bits 7:0 and mask bit 1 enables bits 15:8, for both reads and writes. The lane enable pins are active low. A write changes only the enabled lanes. In returned read data, disabled lanes are 0. A mask of 00 touches no memory byte.
- R4: For a write, output-enable stays high throughout. The write strobe is low for exactly PULSE_CYC = max(ceil(tPWE), ceil(tSD), ceil(tWC)-2) cycles (9 at 5 ns). Ready returns PULSE_CYC+3 edges after acceptance.
- R5: Address and lane enables do not change while chip-select stays low. The write strobe falls at least one clock after chip-select falls, and rises one clock before chip-select rises.
- R6: The controller drives the data bus only during write cycles. It drives only after output-enable has been high for at least TURN_CYC = ceil(tHZ) cycles (4 at 5 ns). After a read, ready returns TURN_CYC cycles after output-enable rises.
- R7: Ready is low while an access is in progress. A request held valid during that time is not accepted, and the memory address stays that of the running access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request accepted this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rsp_valid | output | 1 | One-clock read-data strobe |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| mem_addr | output | 16 | Memory address |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_be_n | output | 2 | Lane enables, active low, bit 0 = low byte |
| mem_dq | inout | 16 | Bidirectional data bus |

## Verification
The assertions assume a memory that releases the bus within the turnaround time once output-enable rises, and that drives only while chip-select and output-enable are low and the write strobe is high. The bench memory model drives its lanes with zero delay under exactly that condition and samples data on the rising write strobe. The requester is assumed to change its inputs only between clock edges. The bench drives all inputs at the falling edge. The bench sweeps 64 addresses, with distinct low bytes and varied high bytes, through every lane mask, including a request held valid across a busy access.

// File: rtl/sram_lane_pkg.sv
`timescale 1ns/1ps
package sram_lane_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 16;
    localparam int LANES  = DATA_W / 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_TURN,
        ST_WSET,
        ST_WPULSE,
        ST_WHOLD
    } seq_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [LANES-1:0]  mask;
    } req_t;

    // Cycles needed to cover a minimum interval, never fewer than one.
    function automatic int ns_to_cyc(input int ns, input int period);
        if (ns <= 0) return 1;
        return (ns + period - 1) / period;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_lane_timer.sv
`timescale 1ns/1ps
module sram_lane_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)             cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/sram_lane_seq.sv
`timescale 1ns/1ps
module sram_lane_seq
    import sram_lane_pkg::*;
#(
    parameter int RD_CYC    = 11,
    parameter int TURN_CYC  = 4,
    parameter int PULSE_CYC = 9
) (
    input  logic clk,
    input  logic rst,
    input  logic req_valid,
    input  logic req_write,
    output logic ready,
    output logic accept,
    output logic capture,
    output logic ce_n,
    output logic oe_n,
    output logic we_n,
    output logic drive
);
    localparam int MAXC  = max2(RD_CYC, max2(TURN_CYC, PULSE_CYC));
    localparam int CNT_W = $clog2(MAXC + 1);

    seq_state_e       state, next;
    logic             load, done;
    logic [CNT_W-1:0] load_val;

    sram_lane_timer #(.W(CNT_W)) u_timer (
        .clk(clk), .rst(rst), .load(load), .load_val(load_val), .done(done)
    );

    always_comb begin
        next     = state;
        load     = 1'b0;
        load_val = '0;
        capture  = 1'b0;
        case (state)
            ST_IDLE: if (req_valid) begin
                if (req_write) begin
                    next = ST_WSET;
                end else begin
                    next     = ST_RD;
                    load     = 1'b1;
                    load_val = CNT_W'(RD_CYC - 1);
                end
            end
            ST_RD: if (done) begin
                capture  = 1'b1;
                next     = ST_TURN;
                load     = 1'b1;
                load_val = CNT_W'(TURN_CYC - 1);
            end
            ST_TURN:   if (done) next = ST_IDLE;
            ST_WSET: begin
                next     = ST_WPULSE;
                load     = 1'b1;
                load_val = CNT_W'(PULSE_CYC - 1);
            end
            ST_WPULSE: if (done) next = ST_WHOLD;
            ST_WHOLD:  next = ST_IDLE;
            default:   next = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= next;
    end

    assign ready  = (state == ST_IDLE);
    assign accept = ready && req_valid;
    assign ce_n   = (state == ST_IDLE) || (state == ST_TURN);
    assign oe_n   = (state != ST_RD);
    assign we_n   = (state != ST_WPULSE);
    assign drive  = (state == ST_WSET) || (state == ST_WPULSE) || (state == ST_WHOLD);

    // Checker counters: cycles output-enable has been high, cycles strobe low.
    logic [CNT_W-1:0] oe_hi_cnt, we_lo_cnt;
    always_ff @(posedge clk) begin
        if (rst) begin
            oe_hi_cnt <= CNT_W'(TURN_CYC);
            we_lo_cnt <= '0;
        end else begin
            if (!oe_n)                          oe_hi_cnt <= '0;
            else if (oe_hi_cnt < CNT_W'(TURN_CYC)) oe_hi_cnt <= oe_hi_cnt + 1'b1;
            if (!we_n) begin
                if (we_lo_cnt < CNT_W'(MAXC)) we_lo_cnt <= we_lo_cnt + 1'b1;
            end else begin
                we_lo_cnt <= '0;
            end
        end
    end

    a_r4_oe_high_in_write: assert property (@(posedge clk) disable iff (rst)
        (!we_n) |-> oe_n);
    a_r4_pulse_len: assert property (@(posedge clk) disable iff (rst)
        $rose(we_n) |-> (we_lo_cnt == CNT_W'(PULSE_CYC)));
    a_r5_we_inside_ce: assert property (@(posedge clk) disable iff (rst)
        (!we_n) |-> (!ce_n && $past(!ce_n)));
    a_r5_ce_after_we: assert property (@(posedge clk) disable iff (rst)
        $rose(we_n) |-> !ce_n);
    a_r6_turnaround: assert property (@(posedge clk) disable iff (rst)
        drive |-> (oe_hi_cnt >= CNT_W'(TURN_CYC)));
    a_r7_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        accept |=> !ready);
endmodule

// File: rtl/sram_lane_dp.sv
`timescale 1ns/1ps
module sram_lane_dp
    import sram_lane_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  req_t              req,
    input  logic              capture,
    input  logic              lanes_on,
    input  logic [DATA_W-1:0] dq_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LANES-1:0]  mem_be_n,
    output logic [DATA_W-1:0] dq_out,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);
    req_t hold;

    always_ff @(posedge clk) begin
        if (rst)         hold <= '0;
        else if (accept) hold <= req;
    end

    always_ff @(posedge clk) begin
        if (rst) rsp_valid <= 1'b0;
        else     rsp_valid <= capture;
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign mem_be_n[i] = !(lanes_on && hold.mask[i]);

        always_ff @(posedge clk) begin
            if (rst)
                rsp_rdata[8*i +: 8] <= '0;
            else if (capture)
                rsp_rdata[8*i +: 8] <= hold.mask[i] ? dq_in[8*i +: 8] : 8'h00;
        end

        a_r3_off_lane_zero: assert property (@(posedge clk) disable iff (rst)
            (rsp_valid && !hold.mask[i]) |-> (rsp_rdata[8*i +: 8] == 8'h00));
    end

    assign mem_addr = hold.addr;
    assign dq_out   = hold.wdata;

    a_r2_single_strobe: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);
endmodule

// File: rtl/sram_lane_ctrl.sv
`timescale 1ns/1ps
module sram_lane_ctrl
    import sram_lane_pkg::*;
#(
    parameter int CLK_NS  = 5,
    parameter int T_RC    = 55,
    parameter int T_AA    = 55,
    parameter int T_DOE   = 25,
    parameter int T_WC    = 55,
    parameter int T_PWE   = 40,
    parameter int T_SD    = 25,
    parameter int T_HZ    = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_mask,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [LANES-1:0]  mem_be_n,
    inout  wire  [DATA_W-1:0] mem_dq
);
    localparam int RD_CYC    = max2(ns_to_cyc(T_RC, CLK_NS),
                                    max2(ns_to_cyc(T_AA, CLK_NS), ns_to_cyc(T_DOE, CLK_NS)));
    localparam int TURN_CYC  = ns_to_cyc(T_HZ, CLK_NS);
    localparam int PULSE_CYC = max2(ns_to_cyc(T_PWE, CLK_NS),
                                    max2(ns_to_cyc(T_SD, CLK_NS), ns_to_cyc(T_WC, CLK_NS) - 2));

    logic accept, capture, drive;
    logic [DATA_W-1:0] dq_out;
    req_t req;

    assign req = '{addr: req_addr, wdata: req_wdata, mask: req_mask};

    sram_lane_seq #(
        .RD_CYC(RD_CYC), .TURN_CYC(TURN_CYC), .PULSE_CYC(PULSE_CYC)
    ) u_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .ready(req_ready), .accept(accept), .capture(capture),
        .ce_n(mem_ce_n), .oe_n(mem_oe_n), .we_n(mem_we_n), .drive(drive)
    );

    sram_lane_dp u_dp (
        .clk(clk), .rst(rst), .accept(accept), .req(req), .capture(capture),
        .lanes_on(!mem_ce_n), .dq_in(mem_dq), .mem_addr(mem_addr),
        .mem_be_n(mem_be_n), .dq_out(dq_out),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    assign mem_dq = drive ? dq_out : {DATA_W{1'bz}};

    a_r5_addr_stable: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce_n && $past(!mem_ce_n)) |-> ($stable(mem_addr) && $stable(mem_be_n)));
    a_r1_idle_strobes: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (mem_ce_n && mem_oe_n && mem_we_n && (&mem_be_n)));
endmodule

// File: tb/sram_lane_ctrl_bench.sv
`timescale 1ns/1ps
module sram_lane_ctrl_bench;
    localparam int PER       = 5;
    localparam int RD_CYC    = (55 + PER - 1) / PER;
    localparam int TURN_CYC  = (20 + PER - 1) / PER;
    localparam int PULSE_CYC = (40 + PER - 1) / PER > (55 + PER - 1) / PER - 2
                             ? (40 + PER - 1) / PER : (55 + PER - 1) / PER - 2;

    logic clk = 1'b0, rst = 1'b1;
    logic valid = 1'b0, write = 1'b0;
    logic [15:0] addr = '0, wdata = '0;
    logic [1:0]  mask = '0;
    logic ready, rsp_valid, ce_n, oe_n, we_n;
    logic [15:0] rdata, maddr;
    logic [1:0]  be_n;
    wire  [15:0] dq;

    int n_chk = 0, n_fail = 0;
    logic [15:0] shadow [0:63];
    logic [15:0] ram [0:255];

    always #2.5 clk = ~clk;

    sram_lane_ctrl u_sram_lane_ctrl (
        .clk(clk), .rst(rst), .req_valid(valid), .req_ready(ready),
        .req_write(write), .req_addr(addr), .req_wdata(wdata), .req_mask(mask),
        .rsp_valid(rsp_valid), .rsp_rdata(rdata), .mem_addr(maddr),
        .mem_ce_n(ce_n), .mem_oe_n(oe_n), .mem_we_n(we_n), .mem_be_n(be_n),
        .mem_dq(dq)
    );

    // Asynchronous memory model, 256 words indexed by the low address byte.
    wire rd_en = !ce_n && !oe_n && we_n;
    assign dq[7:0]  = (rd_en && !be_n[0]) ? ram[maddr[7:0]][7:0]  : 8'bz;
    assign dq[15:8] = (rd_en && !be_n[1]) ? ram[maddr[7:0]][15:8] : 8'bz;
    always @(posedge we_n) begin
        if (!ce_n && !rst) begin
            if (!be_n[0]) ram[maddr[7:0]][7:0]  <= dq[7:0];
            if (!be_n[1]) ram[maddr[7:0]][15:8] <= dq[15:8];
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] addr_of(input int i);
        return {8'(i * 37 + 3), 8'(i) ^ 8'h5a};
    endfunction

    function automatic logic [15:0] lanes(input logic [1:0] m);
        return {{8{m[1]}}, {8{m[0]}}};
    endfunction

    task automatic do_write(input logic [15:0] a, input logic [1:0] m, input logic [15:0] d);
        int n = 0, we_lo = 0, oe_lo = 0;
        bit addr_ok = 1;
        @(negedge clk);
        valid = 1; write = 1; addr = a; mask = m; wdata = d;
        forever begin
            @(negedge clk);
            n++;
            if (n == 1) valid = 0;
            if (!we_n) we_lo++;
            if (!oe_n) oe_lo++;
            if (!ce_n && maddr != a) addr_ok = 0;
            if (ready || n > 100) break;
        end
        chk(we_lo == PULSE_CYC, "R4", "write strobe low cycles", we_lo, PULSE_CYC);
        chk(oe_lo == 0, "R4", "output-enable low during write", oe_lo, 0);
        chk(n == PULSE_CYC + 3, "R4", "write busy cycles", n, PULSE_CYC + 3);
        chk(addr_ok, "R5", "address stable during write", maddr, a);
    endtask

    task automatic do_read(input logic [15:0] a, input logic [1:0] m,
                           input logic [15:0] exp, input bit keep);
        int n = 0, oe_lo = 0, strobes = 0, at = 0, oe_rise = 0;
        bit addr_ok = 1;
        logic [15:0] got = '0;
        @(negedge clk);
        valid = 1; write = 0; addr = a; mask = m;
        forever begin
            @(negedge clk);
            n++;
            if (n == 1 && !keep) valid = 0;
            if (n == 1 && keep) begin write = 1; addr = ~a; wdata = 16'hbeef; mask = 2'b11; end
            if (keep && n == RD_CYC + TURN_CYC - 1) valid = 0;
            if (!oe_n) oe_lo++;
            if (oe_n && oe_lo > 0 && oe_rise == 0) oe_rise = n;
            if (maddr != a) addr_ok = 0;
            if (rsp_valid) begin strobes++; at = n; got = rdata; end
            if (ready || n > 100) break;
        end
        chk(got == exp, "R2/R3", "read data", got, exp);
        chk(strobes == 1 && at == RD_CYC + 1, "R2", "read strobe edge", at, RD_CYC + 1);
        chk(oe_lo == RD_CYC, "R2", "output-enable low cycles", oe_lo, RD_CYC);
        chk(n - oe_rise == TURN_CYC, "R6", "turnaround before ready", n - oe_rise, TURN_CYC);
        chk(addr_ok, keep ? "R7" : "R5", "address held during read", maddr, a);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) ram[i] = '0;
        repeat (5) @(negedge clk);
        // R1: reset values
        chk(ready === 1'b1, "R1", "ready in reset", ready, 1);
        chk({ce_n, oe_n, we_n, be_n} === 5'b11111, "R1", "strobes in reset",
            {ce_n, oe_n, we_n, be_n}, 5'b11111);
        chk(rsp_valid === 1'b0, "R1", "read strobe in reset", rsp_valid, 0);
        rst = 0;
        repeat (3) @(negedge clk);
        chk(ready && {ce_n, oe_n, we_n, be_n} == 5'b11111, "R1", "idle after reset",
            {ready, ce_n, oe_n, we_n, be_n}, 6'b111111);

        // R2, R4: full-word writes then reads over 64 addresses
        for (int i = 0; i < 64; i++) begin
            shadow[i] = 16'(i * 16'h9e37) ^ 16'h1234;
            do_write(addr_of(i), 2'b11, shadow[i]);
        end
        for (int i = 0; i < 64; i++) do_read(addr_of(i), 2'b11, shadow[i], 0);

        // R3: single-lane writes, then reads under every mask
        for (int i = 0; i < 64; i++) begin
            logic [1:0]  m = i[0] ? 2'b10 : 2'b01;
            logic [15:0] d = 16'(i * 16'h0b5d) ^ 16'hc3a1;
            do_write(addr_of(i), m, d);
            shadow[i] = (shadow[i] & ~lanes(m)) | (d & lanes(m));
        end
        for (int i = 0; i < 64; i++) begin
            logic [1:0] m = 2'(i);
            do_read(addr_of(i), m, shadow[i] & lanes(m), 0);
        end

        // R3: mask 00 write changes nothing
        do_write(addr_of(5), 2'b00, 16'h0000);
        do_read(addr_of(5), 2'b11, shadow[5], 0);

        // R7: request held valid during a read is not taken
        do_read(addr_of(9), 2'b11, shadow[9], 1);
        do_read(~addr_of(9), 2'b11, ram[8'(~addr_of(9))], 0);
        chk(ram[8'(~addr_of(9))] != 16'hbeef, "R7", "held request not written",
            ram[8'(~addr_of(9))], 0);
        do_read(addr_of(9), 2'b11, shadow[9], 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog run did not finish actual=0 expected=1");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule